// File: doc/BRIEF.md
# Hybrid Static-Dynamic Branch Direction Predictor

This block sits in the fetch stage and produces a taken or not-taken guess for each branch that is looked up. The guess comes from a small direct-mapped table of two-bit saturating counters. The table is indexed by a slice of the instruction address just above the word-alignment bits. Branches whose addresses share that slice share an entry, and that aliasing is accepted. An entry that no branch has ever trained carries no history. For such an entry the block falls back to a fixed rule on the branch's displacement sign: a branch that jumps backward, as loop closers do, is guessed taken, and a branch that jumps forward is guessed not taken.

Lookup is purely combinational from the registered table, so the answer is available in the same cycle as the request. When a branch resolves, the pipeline presents its address, its actual outcome and the direction that had been predicted for it. The table entry is trained at the next clock edge, and two saturating counters record the number of resolved branches and the number that were mispredicted.

Top module: `hybrid_bpred`

## Requirements
- R1: After synchronous reset every table entry is untrained: a valid lookup of any address reports `pred_trained`=0, and `branch_count` and `miss_count` read 0.
- R2: For a valid lookup that hits an untrained entry, `pred_taken` equals `lk_backward`, where 1 means a negative displacement.
- R3: For a valid lookup that hits a trained entry, `pred_trained`=1 and `pred_taken` is the upper bit of the entry's two-bit counter. Counter values 00 and 01 mean not taken, and 10 and 11 mean taken. `lk_backward` has no effect.
- R4: The first update to an untrained entry marks it trained and loads counter 10 when the outcome is taken, or 01 when the outcome is not taken.
- R5: An update to a trained entry increments the counter on a taken outcome and decrements it on a not-taken outcome. The counter holds at 11 and at 00.
- R6: The entry is selected by address bits [IDX_W+1:2]. Addresses that differ only in bits [1:0] or above bit IDX_W+1 use the same entry.
- R7: An update becomes visible to lookups in the cycle after it is presented. A lookup of the same entry in the update cycle still sees the old state.
- R8: While `lk_valid`=0, both `pred_taken` and `pred_trained` are 0.
- R9: While `up_valid`=0, no table entry and neither counter changes, whatever the other update inputs are.
- R10: Each accepted update adds one to `branch_count`. It also adds one to `miss_count` when `up_taken` differs from `up_predicted`. Both counters hold at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_backward | input | 1 | 1 when the branch displacement is negative |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_trained | output | 1 | 1 when the prediction came from a trained entry |
| up_valid | input | 1 | Resolved-branch update valid |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_predicted | input | 1 | Direction that had been predicted for this branch |
| branch_count | output | CNT_W | Saturating count of resolved branches |
| miss_count | output | CNT_W | Saturating count of mispredicted branches |

## Verification
The lookup outputs follow the lookup inputs in the same cycle. The bench therefore drives them on the falling edge and compares one nanosecond later, before any rising edge intervenes. Updates and both counters are registered, so each is due exactly one rising edge after it is presented. The bench applies an update on a falling edge, lets one rising edge pass, and checks the entry and the counters on the following falling edge. It also checks the same entry within the update cycle itself, to confirm that the old state is still visible there. A reference model of counters and trained flags is advanced only at those points, so each expected value always matches the cycle in which it is sampled.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int ALIGN_BITS = 2;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic trained;
        ctr_e ctr;
    } entry_t;

    // Upper counter bit decides the direction.
    function automatic logic ctr_says_taken(ctr_e c);
        logic [1:0] v;
        v = c;
        return v[1];
    endfunction

    // Fallback for entries without history: loop-closing branches jump back.
    function automatic logic static_guess(logic backward);
        return backward;
    endfunction

    // Next entry contents after one resolved outcome.
    function automatic entry_t entry_train(entry_t cur, logic taken);
        entry_t nxt;
        nxt.trained = 1'b1;
        if (!cur.trained) begin
            nxt.ctr = taken ? CTR_WEAK_T : CTR_WEAK_NT;
        end else begin
            unique case (cur.ctr)
                CTR_STRONG_NT: nxt.ctr = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
                CTR_WEAK_NT:   nxt.ctr = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
                CTR_WEAK_T:    nxt.ctr = taken ? CTR_STRONG_T : CTR_WEAK_NT;
                default:       nxt.ctr = taken ? CTR_STRONG_T : CTR_WEAK_T;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/hbp_index.sv
module hbp_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    import hbp_pkg::*;

    localparam int TOP_BIT = ALIGN_BITS + IDX_W;

    assign idx = pc[ALIGN_BITS +: IDX_W];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:TOP_BIT], pc[ALIGN_BITS-1:0]};
endmodule

// File: rtl/hbp_table.sv
module hbp_table #(
    parameter int IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     rd_idx,
    output hbp_pkg::entry_t      rd_entry,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_taken
);
    import hbp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    entry_t entries [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst) begin
                    entries[g] <= '{trained: 1'b0, ctr: CTR_WEAK_NT};
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    entries[g] <= entry_train(entries[g], wr_taken);
                end
            end
        end
    endgenerate

    assign rd_entry = entries[rd_idx];
endmodule

// File: rtl/hbp_stats.sv
module hbp_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic             ev_miss,
    output logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] misses
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            total  <= '0;
            misses <= '0;
        end else if (ev_valid) begin
            if (total != CNT_MAX)
                total <= total + CNT_W'(1);
            if (ev_miss && misses != CNT_MAX)
                misses <= misses + CNT_W'(1);
        end
    end
endmodule

// File: rtl/hybrid_bpred.sv
module hybrid_bpred #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic             lk_backward,
    output logic             pred_taken,
    output logic             pred_trained,
    input  logic             up_valid,
    input  logic [PC_W-1:0]  up_pc,
    input  logic             up_taken,
    input  logic             up_predicted,
    output logic [CNT_W-1:0] branch_count,
    output logic [CNT_W-1:0] miss_count
);
    import hbp_pkg::*;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    entry_t           lk_entry;

    hbp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) lk_index_i (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    hbp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) up_index_i (
        .pc  (up_pc),
        .idx (up_idx)
    );

    hbp_table #(.IDX_W(IDX_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_entry (lk_entry),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    hbp_stats #(.CNT_W(CNT_W)) stats_i (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (up_valid),
        .ev_miss  (up_taken ^ up_predicted),
        .total    (branch_count),
        .misses   (miss_count)
    );

    always_comb begin
        pred_trained = lk_valid & lk_entry.trained;
        if (!lk_valid)
            pred_taken = 1'b0;
        else if (lk_entry.trained)
            pred_taken = ctr_says_taken(lk_entry.ctr);
        else
            pred_taken = static_guess(lk_backward);
    end
endmodule

// File: rtl/hybrid_bpred_checker.sv
module hybrid_bpred_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_backward,
    input logic             pred_taken,
    input logic             pred_trained,
    input logic             up_valid,
    input logic [PC_W-1:0]  up_pc,
    input logic             up_taken,
    input logic             up_predicted,
    input logic [CNT_W-1:0] branch_count,
    input logic [CNT_W-1:0] miss_count
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [IDX_W-1:0] chk_lk_slot;
    logic [IDX_W-1:0] chk_up_slot;
    assign chk_lk_slot = lk_pc[IDX_W+1:2];
    assign chk_up_slot = up_pc[IDX_W+1:2];

    // R1: counters cleared by reset
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (branch_count == '0 && miss_count == '0));

    // R8: no prediction without a request
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!pred_taken && !pred_trained));

    // R2: untrained entries follow the displacement sign
    a_r2_static_rule: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !pred_trained) |-> (pred_taken == lk_backward));

    // R7: an updated entry is trained from the next cycle
    a_r7_next_cycle: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> (!lk_valid || chk_lk_slot != $past(chk_up_slot) || pred_trained));

    // R9: counters hold when no update is presented
    a_r9_no_update_hold: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> ($stable(branch_count) && $stable(miss_count)));

    // R10: each update counts once until saturation
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        (up_valid && branch_count != FULL) |=> (branch_count == $past(branch_count) + CNT_W'(1)));

    // R10: a correct guess never adds a miss
    a_r10_hit_no_miss: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_taken == up_predicted) |=> $stable(miss_count));

    // R10: misses never exceed branches
    a_r10_miss_bound: assert property (@(posedge clk) disable iff (rst)
        miss_count <= branch_count);

    logic unused_chk;
    assign unused_chk = ^{lk_pc, up_pc};
endmodule

bind hybrid_bpred hybrid_bpred_checker #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) checker_i (.*);

// File: tb/hybrid_bpred_tb_top.sv
`timescale 1ns/1ps
module hybrid_bpred_tb_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int CNT_W = 6;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst;
    logic lk_valid, lk_backward, pred_taken, pred_trained;
    logic [PC_W-1:0] lk_pc, up_pc;
    logic up_valid, up_taken, up_predicted;
    logic [CNT_W-1:0] branch_count, miss_count;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_trained [DEPTH];
    int m_ctr     [DEPTH];
    int exp_tot = 0;
    int exp_miss = 0;

    always #10 clk = ~clk;

    hybrid_bpred #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (.*);

    function automatic logic [PC_W-1:0] mk_pc(int salt, int slot, int low);
        return (PC_W'(salt) << (IDX_W + 2)) | (PC_W'(slot) << 2) | PC_W'(low & 3);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic look(string req, logic [PC_W-1:0] pc, logic back, int slot);
        int et, etr;
        lk_valid = 1'b1; lk_pc = pc; lk_backward = back;
        #1;
        etr = m_trained[slot];
        et  = etr != 0 ? (m_ctr[slot] >= 2 ? 1 : 0) : int'(back);
        check(req, int'(pred_trained), etr);
        check(req, int'(pred_taken), et);
    endtask

    task automatic model_update(int slot, logic t, logic p);
        if (m_trained[slot] == 0) begin
            m_trained[slot] = 1;
            m_ctr[slot] = t ? 2 : 1;
        end else if (t) begin
            m_ctr[slot] = (m_ctr[slot] == 3) ? 3 : m_ctr[slot] + 1;
        end else begin
            m_ctr[slot] = (m_ctr[slot] == 0) ? 0 : m_ctr[slot] - 1;
        end
        if (exp_tot < CMAX) exp_tot++;
        if (t != p && exp_miss < CMAX) exp_miss++;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_trained[i] = 0; m_ctr[i] = 0; end
        rst = 1'b1; lk_valid = 1'b0; lk_pc = '0; lk_backward = 1'b0;
        up_valid = 1'b0; up_pc = '0; up_taken = 1'b0; up_predicted = 1'b0;
        @(negedge clk); step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 branch_count", int'(branch_count), 0);
        check("R1 miss_count", int'(miss_count), 0);
        // R1/R2 every slot untrained, static rule both signs
        for (int s = 0; s < DEPTH; s++) begin
            look("R1 R2 backward", mk_pc(s * 3 + 1, s, s), 1'b1, s);
            look("R1 R2 forward", mk_pc(s * 5 + 2, s, s + 1), 1'b0, s);
        end

        // R8 idle lookup
        lk_valid = 1'b0; lk_backward = 1'b1; #1;
        check("R8 taken idle", int'(pred_taken), 0);
        check("R8 trained idle", int'(pred_trained), 0);

        // R3 R4 R5 R6 R10 sweep: slot s gets (s%6) taken outcomes then not-taken
        for (int s = 0; s < DEPTH; s++) begin
            for (int k = 0; k < 6; k++) begin
                logic t, p;
                t = (k < (s % 6));
                p = logic'(k % 2);
                up_valid = 1'b1; up_pc = mk_pc(s + 7 * k, s, k); up_taken = t; up_predicted = p;
                step();
                up_valid = 1'b0;
                model_update(s, t, p);
                // alias address (R6), backward opposite to history (R3)
                look("R3 R4 R5 R6 trained", mk_pc(100 + s * k, s, 3 - k),
                     logic'(m_ctr[s] < 2), s);
                check("R10 branch_count", int'(branch_count), exp_tot);
                check("R10 miss_count", int'(miss_count), exp_miss);
            end
        end

        // R9 update inputs without up_valid leave state alone
        lk_valid = 1'b0;
        up_valid = 1'b0; up_pc = mk_pc(9, 5, 0); up_taken = ~(m_ctr[5] >= 2); up_predicted = 1'b1;
        step(); step();
        look("R9 entry unchanged", mk_pc(9, 5, 0), 1'b0, 5);
        check("R9 branch_count", int'(branch_count), exp_tot);
        check("R9 miss_count", int'(miss_count), exp_miss);

        // R7 same-cycle update of slot 0 (currently strong not-taken): old then new
        up_valid = 1'b1; up_pc = mk_pc(1, 0, 0); up_taken = 1'b1; up_predicted = 1'b1;
        look("R7 same cycle old", mk_pc(2, 0, 1), 1'b1, 0);
        step();
        up_valid = 1'b0;
        model_update(0, 1'b1, 1'b1);
        look("R7 next cycle new", mk_pc(2, 0, 1), 1'b1, 0);
        up_valid = 1'b1; up_taken = 1'b1;
        step();
        up_valid = 1'b0;
        model_update(0, 1'b1, 1'b1);
        look("R7 R5 now taken", mk_pc(3, 0, 2), 1'b0, 0);
        check("R10 saturated count", int'(branch_count), exp_tot);

        // R1 reset again clears trained flags
        rst = 1'b1; step(); rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) m_trained[i] = 0;
        exp_tot = 0; exp_miss = 0;
        look("R1 after rerst", mk_pc(4, 7, 0), 1'b1, 7);
        check("R1 count after rerst", int'(branch_count), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule